// File: doc/BRIEF.md
# Event and Condition Status Word with Masked Interrupt

This block builds a controller's 32-bit status word from two kinds of flag. Sticky flags capture one-cycle event pulses and keep them until software writes ones to a clear register. Live flags simply track the present level of a hardware condition, such as a buffer being full or empty. A mask register selects which status bits may raise the single interrupt request line.

Bus decoding lives outside the block. The block sees only a write strobe with data for the clear register and a write strobe with data for the mask register. It drives the status word, the mask readback and the interrupt line. The positions that are sticky and the positions that are live are parameters. By default, bits 29, 21 and 11..0 are sticky, bits 20..12 are live, and every other position reads as zero.

Top module: `status_merge_unit`

## Requirements
- R1: While `rst` is high and after it falls, `status_o`, `mask_o` and `irq_o` read 0 until a new event, live level or mask write arrives.
- R2: An `evt_i` pulse on a sticky position (29, 21, 11..0) sets that bit of `status_o` after the next rising edge. The bit stays set after the pulse ends.
- R3: With `clr_we` high, each 1 in `clr_data` clears the matching sticky bit at the next edge, and each 0 leaves its bit unchanged. With `clr_we` low, `clr_data` has no effect.
- R4: When an event pulse and a clear hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Each live position (20..12) of `status_o` equals the value of `live_i` at the previous rising edge. It rises and falls with the input.
- R6: Clears aimed at live or unused positions have no effect. Event pulses on live or unused positions have no effect. Unused positions (31, 30, 28..22) always read 0.
- R7: `live_i` bits at sticky or unused positions never show on `status_o`.
- R8: A mask write with `msk_we` high loads `msk_data` into `mask_o` at the next edge. Without a write, `mask_o` holds its value.
- R9: `irq_o` equals the OR over all bits of (`status_o` AND `mask_o`) as sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 32 | One-cycle event pulses, one per bit |
| live_i | input | 32 | Live condition levels, one per bit |
| clr_we | input | 1 | Clear register write strobe |
| clr_data | input | 32 | Write-one-to-clear data |
| msk_we | input | 1 | Mask register write strobe |
| msk_data | input | 32 | New mask value |
| status_o | output | 32 | Merged status word |
| mask_o | output | 32 | Mask readback |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench aims at cases where the flag types meet:
- A clear and an event on the same bit in the same cycle. A design that lets the clear win would lose that event.
- Clears sent to live and unused positions. A design that clears the wrong positions would drop or corrupt live bits.
- Events and live levels fed into the wrong positions. A design that fails to filter by position would leak them into unused or sticky bits.
- A clear with data but no strobe. A design that ignores the strobe would wipe flags.
- Live bits that fall. A design that latches them would keep them set.

The interrupt is checked after every step against the previous status and mask. This catches a line that is off by one cycle, unmasked, or tied to the wrong bits.

// File: rtl/stu_pkg.sv
package stu_pkg;
  localparam int STU_W = 32;
  localparam logic [STU_W-1:0] STU_STICKY_DEF = 32'h2020_0FFF;
  localparam logic [STU_W-1:0] STU_LIVE_DEF   = 32'h001F_F000;
endpackage

// File: rtl/stu_sticky_bank.sv
module stu_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] STICKY_SEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] sticky_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY_SEL[i]) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else if (evt_i[i])
          bit_q <= 1'b1;
        else if (clr_we_i && clr_data_i[i])
          bit_q <= 1'b0;
      end
      assign sticky_o[i] = bit_q;
    end else begin : g_none
      assign sticky_o[i] = 1'b0;
    end
  end

  // R2: a set bit that is not cleared stays set
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((sticky_o & $past(sticky_o & ~(clr_we_i ? clr_data_i : '0)))
              == $past(sticky_o & ~(clr_we_i ? clr_data_i : '0))));

  // R4: an event is never lost, even under a same-cycle clear
  p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((sticky_o & $past(evt_i & STICKY_SEL)) == $past(evt_i & STICKY_SEL)));

  // R3: a cleared bit with no event is low afterwards
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((sticky_o & $past(clr_we_i ? (clr_data_i & ~evt_i) : '0)) == '0));
endmodule

// File: rtl/stu_live_stage.sv
module stu_live_stage #(
  parameter int W = 32,
  parameter logic [W-1:0] LIVE_SEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] live_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE_SEL[i]) begin : g_track
      logic lvl_q;
      always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= live_i[i];
      end
      assign live_o[i] = lvl_q;
    end else begin : g_none
      assign live_o[i] = 1'b0;
    end
  end

  // R5: live positions follow the input one edge later
  p_live_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((live_o & LIVE_SEL) == ($past(live_i) & LIVE_SEL)));
endmodule

// File: rtl/stu_mask_reg.sv
module stu_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (we_i) mask_q <= data_i;
  end
  assign mask_o = mask_q;

  // R8: mask holds without a write
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_q));
  // R8: a write loads the data
  p_mask_load_r8: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mask_q == $past(data_i)));
endmodule

// File: rtl/stu_irq_reduce.sv
module stu_irq_reduce #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_i & mask_i);
  end
  assign irq_o = irq_q;

  // R9: request reflects the previous cycle's masked status
  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_q == ($past(status_i & mask_i) != '0)));
endmodule

// File: rtl/status_merge_unit.sv
module status_merge_unit
  import stu_pkg::*;
#(
  parameter int W = STU_W,
  parameter logic [W-1:0] STICKY_SEL = STU_STICKY_DEF,
  parameter logic [W-1:0] LIVE_SEL   = STU_LIVE_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] live_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic         msk_we,
  input  logic [W-1:0] msk_data,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  localparam logic [W-1:0] UNUSED_SEL = ~(STICKY_SEL | LIVE_SEL);

  logic [W-1:0] sticky_w;
  logic [W-1:0] live_w;

  stu_sticky_bank #(.W(W), .STICKY_SEL(STICKY_SEL)) u_sticky (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_we_i(clr_we),
    .clr_data_i(clr_data), .sticky_o(sticky_w));

  stu_live_stage #(.W(W), .LIVE_SEL(LIVE_SEL)) u_live (
    .clk(clk), .rst(rst), .live_i(live_i), .live_o(live_w));

  stu_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .we_i(msk_we), .data_i(msk_data), .mask_o(mask_o));

  assign status_o = sticky_w | live_w;

  stu_irq_reduce #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .status_i(status_o), .mask_i(mask_o), .irq_o(irq_o));

  // R6: unused positions never read as set
  p_unused_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (status_o & UNUSED_SEL) == '0);
  // R1: outputs cleared after a reset cycle
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (status_o == '0 && mask_o == '0 && irq_o == 1'b0));
endmodule

// File: tb/status_merge_unit_tb.sv
module status_merge_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] evt_i, live_i, clr_data, msk_data;
  logic        clr_we, msk_we;
  logic [31:0] status_o, mask_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  status_merge_unit u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .live_i(live_i),
    .clr_we(clr_we), .clr_data(clr_data), .msk_we(msk_we),
    .msk_data(msk_data), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o));

  typedef struct packed {
    logic [31:0] evt;
    logic [31:0] live;
    logic        cwe;
    logic [31:0] cdat;
    logic        mwe;
    logic [31:0] mdat;
    logic [31:0] exp_st;
    logic [31:0] exp_mk;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_0001, 32'h0},          // R2 set
    '{32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_0001, 32'h0},                  // R2 hold
    '{32'h2020_0000, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h2020_0001, 32'h0},          // R2 high sticky
    '{32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0000_0001, 32'h2020_0001, 32'h1},          // R8 load
    '{32'h0, 32'h0, 1'b1, 32'h0000_0001, 1'b0, 32'h0, 32'h2020_0000, 32'h1},          // R3 clear
    '{32'h0, 32'h0000_5000, 1'b0, 32'h0, 1'b0, 32'h0, 32'h2020_5000, 32'h1},          // R5 rise
    '{32'h0, 32'h0000_5000, 1'b1, 32'hC01F_F000, 1'b0, 32'h0, 32'h2020_5000, 32'h1},  // R6 clear
    '{32'hC01F_F000, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h2020_0000, 32'h1},          // R6 event
    '{32'h0, 32'hDFE0_0FFF, 1'b0, 32'h0, 1'b0, 32'h0, 32'h2020_0000, 32'h1},          // R7
    '{32'h0000_0800, 32'h0, 1'b1, 32'h2000_0800, 1'b0, 32'h0, 32'h0020_0800, 32'h1},  // R4
    '{32'h0, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0020_0800, 32'h1},          // R3 no strobe
    '{32'h0, 32'h0, 1'b1, 32'h0020_0000, 1'b1, 32'h0000_1000, 32'h0000_0800, 32'h0000_1000}, // R3/R8
    '{32'h0, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_1800, 32'h0000_1000},  // R5
    '{32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_0800, 32'h0000_1000},          // R5 fall
    '{32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0, 32'h0000_1000}           // R3 all
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_i = '0; live_i = '0; clr_we = 1'b0; clr_data = '0;
    msk_we = 1'b0; msk_data = '0;
  endtask

  initial begin
    logic [31:0] prev_st;
    logic [31:0] prev_mk;
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    check("R1 status in reset", status_o, 32'h0);
    check("R1 mask in reset", mask_o, 32'h0);
    check("R1 irq in reset", {31'h0, irq_o}, 32'h0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R1 status after reset", status_o, 32'h0);

    prev_st = 32'h0;
    prev_mk = 32'h0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt_i = VECS[i].evt; live_i = VECS[i].live;
      clr_we = VECS[i].cwe; clr_data = VECS[i].cdat;
      msk_we = VECS[i].mwe; msk_data = VECS[i].mdat;
      @(posedge clk); #1;
      check($sformatf("R2-group vec %0d status", i), status_o, VECS[i].exp_st);
      check($sformatf("R8 vec %0d mask", i), mask_o, VECS[i].exp_mk);
      check($sformatf("R9 vec %0d irq", i), {31'h0, irq_o},
            {31'h0, |(prev_st & prev_mk)});
      prev_st = VECS[i].exp_st;
      prev_mk = VECS[i].exp_mk;
    end

    // R9: irq from a live bit under mask, then drop
    @(negedge clk);
    idle_inputs();
    live_i = 32'h0000_1000;
    @(posedge clk); #1;
    check("R9 irq lags status", {31'h0, irq_o}, 32'h0);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    check("R9 irq asserted", {31'h0, irq_o}, 32'h1);
    @(posedge clk); #1;
    check("R9 irq deasserted", {31'h0, irq_o}, 32'h0);

    // R1: mid-run reset clears mask and sticky flags
    @(negedge clk);
    evt_i = 32'h0000_0004; msk_we = 1'b1; msk_data = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    check("R2 set before reset", status_o, 32'h0000_0004);
    @(negedge clk); idle_inputs(); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 status cleared", status_o, 32'h0);
    check("R1 mask cleared", mask_o, 32'h0);
    check("R1 irq cleared", {31'h0, irq_o}, 32'h0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule